// File: doc/BRIEF.md
# Multiplexed Parallel Bus Address Sequencer

This block runs the master side of a parallel external bus. A request carries an address, a write byte and a read/write flag. The block places the address on the bus in one of four ways. It can drive the whole address on dedicated pins for the entire cycle, or it can send one, two or three time-multiplexed address slices over the shared data lines. Each slice gets its own one-clock latch strobe. After the address, the block runs the data phase, in which it drives write data or samples read data into a holding register.

A second setting picks a full 8-bit data port or a narrow 4-bit data port. With a narrow port, each address slice is a nibble on data lines 3:0. The data byte then moves as two nibble beats, low nibble first. The mode and the port width are captured when a request is accepted. New requests wait until the busy flag drops.

Top module: `pbus_seq`

## Requirements
- R1: Mode encoding: 00 means demultiplexed (no latch strobe), 01 means one address phase (low strobe), 10 means two (low then high) and 11 means three (low, high, upper). The address phases always come in the order low, high, upper, and the data phase comes after them. No two of the five strobes are ever high together.
- R2: In each address phase, the latch strobe is high for exactly one clock while the slice is on the data lines. In the next clock the strobe is low and the same slice stays on the lines. The data bus is driven in both clocks.
- R3: 8-bit port (size value anything but 01): the low slice is addr[7:0], the high slice is addr[15:8] and the upper slice is {0, addr[22:16]}. Dedicated pins: addr[9:0] in mode 00, {addr[9:8], 8'h00} in mode 01, and zero in modes 10 and 11.
- R4: 4-bit port (size value 01): each slice is a nibble on lines 3:0 with lines 7:4 at zero. The low slice is addr[3:0], the high slice is addr[7:4] and the upper slice is addr[11:8]. Dedicated pins: addr[9:0] in mode 00, {addr[9:4], 4'h0} in mode 01, {addr[9:8], 8'h00} in mode 10 and {addr[13:12], 8'h00} in mode 11.
- R5: The dedicated address pins hold one value for every busy cycle and are zero while idle. Address bits outside the selected mode's reach have no effect on any output.
- R6: The data phase is one beat of DATA_LEN clocks for an 8-bit port. For a 4-bit port it is two beats of DATA_LEN clocks each: the low nibble first, then the high nibble.
- R7: In a write, the write strobe is high in every data clock and the data bus is driven in every busy clock. The lines carry the write byte, or {4'h0, nibble} with a 4-bit port.
- R8: In a read, the read strobe is high in every data clock and the bus is released in those clocks. The input is sampled only on the last clock of each beat into the holding register. An 8-bit port captures the whole byte. A 4-bit port takes lines 3:0 into bits 3:0 on the first beat and into bits 7:4 on the second. Writes leave the holding register unchanged.
- R9: A request is accepted on a rising edge with the request valid and busy low. Busy is then high for exactly 2×phases + beats×DATA_LEN clocks, and is low for at least one clock before the next acceptance.
- R10: While busy is high, the request valid input, the address, the data, the mode and the size inputs have no effect on the running transfer.
- R11: After reset, busy, all strobes, the bus enable, the dedicated pins and the holding register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | Request address |
| reqWdata | input | 8 | Write byte |
| addrMode | input | 2 | Address phase mode |
| portSize | input | 2 | Data port width select |
| busy | output | 1 | Transfer in progress |
| busDataOut | output | 8 | Shared data lines, outgoing value |
| busDataOe | output | 1 | Drive enable for the data lines |
| busDataIn | input | 8 | Shared data lines, incoming value |
| addrPins | output | 10 | Dedicated address pins |
| strobeLow | output | 1 | Low address latch strobe |
| strobeHigh | output | 1 | High address latch strobe |
| strobeUpper | output | 1 | Upper address latch strobe |
| rdStrobe | output | 1 | Read data strobe |
| wrStrobe | output | 1 | Write data strobe |
| rdHold | output | 8 | Read data holding register |

## Verification
Writes are run in all four modes with both port widths. This shows that each mode produces the right number of phases and that each width places the right address slice on the data lines and the dedicated pins. An address with every bit set is used alongside a mixed pattern, so that bits beyond a mode's reach would show up on the pins or lines if they leaked. In reads, the bench drives the inverse of the read value on the first clock of each beat, which separates sampling on the last clock from sampling on any other clock. A transfer in which the inputs change and the request is held high during busy shows whether the mode, width and address were captured at acceptance.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int ADDR_W = 23;
  localparam int BUS_W  = 8;
  localparam int PIN_W  = 10;
  localparam int NIB_W  = BUS_W / 2;
  localparam int NUM_LATCH = 3;

  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_ONE   = 2'b01,
    MODE_TWO   = 2'b10,
    MODE_THREE = 2'b11
  } addrMode_e;

  localparam logic [1:0] SIZE_NIBBLE = 2'b01;

  // strobes passed from control to datapath
  typedef struct packed {
    logic       load;
    logic       active;
    logic       addrDrive;
    logic       latch;
    logic [1:0] phase;
    logic       dataDrive;
    logic       beat;
    logic       sample;
    logic [1:0] mode;
    logic       nibble;
  } seqCtl_t;

  function automatic logic [BUS_W-1:0] addrSlice(input logic nibble,
                                                 input logic [1:0] phase,
                                                 input logic [ADDR_W-1:0] a);
    logic [BUS_W-1:0] s;
    if (nibble) begin
      case (phase)
        2'd0:    s = {{NIB_W{1'b0}}, a[3:0]};
        2'd1:    s = {{NIB_W{1'b0}}, a[7:4]};
        default: s = {{NIB_W{1'b0}}, a[11:8]};
      endcase
    end else begin
      case (phase)
        2'd0:    s = a[7:0];
        2'd1:    s = a[15:8];
        default: s = {1'b0, a[22:16]};
      endcase
    end
    return s;
  endfunction

  function automatic logic [PIN_W-1:0] pinValue(input logic [1:0] mode,
                                                input logic nibble,
                                                input logic [ADDR_W-1:0] a);
    logic [PIN_W-1:0] p;
    p = '0;
    case (mode)
      MODE_DEMUX: p = a[PIN_W-1:0];
      MODE_ONE:   p = nibble ? {a[9:4], 4'h0} : {a[9:8], 8'h00};
      MODE_TWO:   p = nibble ? {a[9:8], 8'h00} : '0;
      default:    p = nibble ? {a[13:12], 8'h00} : '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int DATA_LEN = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] addrMode,
  input  logic [1:0] portSize,
  output seqCtl_t    ctl,
  output logic       busy
);

  localparam int CNT_W = (DATA_LEN > 1) ? $clog2(DATA_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_HOLD, S_DATA} seqState_e;

  seqState_e        state;
  logic [1:0]       phase;
  logic [1:0]       modeQ;
  logic             nibQ;
  logic             beat;
  logic [CNT_W-1:0] cnt;
  logic             accept;
  logic             lastClk;

  assign accept  = (state == S_IDLE) && reqValid;
  assign lastClk = (state == S_DATA) && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= '0;
      modeQ <= '0;
      nibQ  <= 1'b0;
      beat  <= 1'b0;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            modeQ <= addrMode;
            nibQ  <= (portSize == SIZE_NIBBLE);
            phase <= '0;
            beat  <= 1'b0;
            cnt   <= '0;
            state <= (addrMode == MODE_DEMUX) ? S_DATA : S_LATCH;
          end
        end
        S_LATCH: state <= S_HOLD;
        S_HOLD: begin
          if (phase == modeQ - 2'd1) begin
            state <= S_DATA;
          end else begin
            phase <= phase + 2'd1;
            state <= S_LATCH;
          end
        end
        default: begin
          if (lastClk) begin
            cnt <= '0;
            if (nibQ && !beat) beat <= 1'b1;
            else               state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.load      = accept;
    ctl.active    = (state != S_IDLE);
    ctl.addrDrive = (state == S_LATCH) || (state == S_HOLD);
    ctl.latch     = (state == S_LATCH);
    ctl.phase     = phase;
    ctl.dataDrive = (state == S_DATA);
    ctl.beat      = beat;
    ctl.sample    = lastClk;
    ctl.mode      = modeQ;
    ctl.nibble    = nibQ;
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/pbus_dpath.sv
module pbus_dpath
  import pbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [BUS_W-1:0]  busDataIn,
  output logic [BUS_W-1:0]  busDataOut,
  output logic              busDataOe,
  output logic [PIN_W-1:0]  addrPins,
  output logic [NUM_LATCH-1:0] latchStb,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic [BUS_W-1:0]  rdHold
);

  logic [ADDR_W-1:0] addrQ;
  logic [BUS_W-1:0]  wdataQ;
  logic              writeQ;
  logic [BUS_W-1:0]  holdQ;
  logic [BUS_W-1:0]  wrBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ <= '0;
    end else if (ctl.sample && !writeQ) begin
      if (!ctl.nibble)   holdQ <= busDataIn;
      else if (ctl.beat) holdQ[BUS_W-1:NIB_W] <= busDataIn[NIB_W-1:0];
      else               holdQ[NIB_W-1:0]     <= busDataIn[NIB_W-1:0];
    end
  end

  assign wrBeat = !ctl.nibble ? wdataQ :
                  ctl.beat    ? {{NIB_W{1'b0}}, wdataQ[BUS_W-1:NIB_W]}
                              : {{NIB_W{1'b0}}, wdataQ[NIB_W-1:0]};

  always_comb begin
    busDataOut = '0;
    if (ctl.addrDrive)                busDataOut = addrSlice(ctl.nibble, ctl.phase, addrQ);
    else if (ctl.dataDrive && writeQ) busDataOut = wrBeat;
  end

  assign busDataOe = ctl.addrDrive || (ctl.dataDrive && writeQ);
  assign addrPins  = ctl.active ? pinValue(ctl.mode, ctl.nibble, addrQ) : '0;
  assign rdStrobe  = ctl.dataDrive && !writeQ;
  assign wrStrobe  = ctl.dataDrive && writeQ;
  assign rdHold    = holdQ;

  for (genvar p = 0; p < NUM_LATCH; p++) begin : g_latch
    assign latchStb[p] = ctl.latch && (ctl.phase == 2'(p));
  end

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DATA_LEN = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [22:0] reqAddr,
  input  logic [7:0]  reqWdata,
  input  logic [1:0]  addrMode,
  input  logic [1:0]  portSize,
  output logic        busy,
  output logic [7:0]  busDataOut,
  output logic        busDataOe,
  input  logic [7:0]  busDataIn,
  output logic [9:0]  addrPins,
  output logic        strobeLow,
  output logic        strobeHigh,
  output logic        strobeUpper,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic [7:0]  rdHold
);

  seqCtl_t              ctl;
  logic [NUM_LATCH-1:0] latchStb;

  pbus_ctrl #(.DATA_LEN(DATA_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .addrMode (addrMode),
    .portSize (portSize),
    .ctl      (ctl),
    .busy     (busy)
  );

  pbus_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .busDataOut (busDataOut),
    .busDataOe  (busDataOe),
    .addrPins   (addrPins),
    .latchStb   (latchStb),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .rdHold     (rdHold)
  );

  assign strobeLow   = latchStb[0];
  assign strobeHigh  = latchStb[1];
  assign strobeUpper = latchStb[2];

endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [7:0] busDataOut,
  input logic       busDataOe,
  input logic [9:0] addrPins,
  input logic       strobeLow,
  input logic       strobeHigh,
  input logic       strobeUpper,
  input logic       rdStrobe,
  input logic       wrStrobe
);

  logic anyLatch;
  assign anyLatch = strobeLow | strobeHigh | strobeUpper;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobeLow, strobeHigh, strobeUpper, rdStrobe, wrStrobe})); // R1

  AST_HIGH_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeHigh) |-> $past(strobeLow, 2)); // R1

  AST_UPPER_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeUpper) |-> $past(strobeHigh, 2)); // R1

  AST_LATCH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    anyLatch |=> (!anyLatch && $stable(busDataOut) && busDataOe)); // R2

  AST_PINS_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(addrPins)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (addrPins == 10'd0 && !busDataOe && !anyLatch && !rdStrobe && !wrStrobe)); // R5

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> busDataOe); // R7

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> !busDataOe); // R8

endmodule

bind pbus_seq pbus_seq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .busDataOut  (busDataOut),
  .busDataOe   (busDataOe),
  .addrPins    (addrPins),
  .strobeLow   (strobeLow),
  .strobeHigh  (strobeHigh),
  .strobeUpper (strobeUpper),
  .rdStrobe    (rdStrobe),
  .wrStrobe    (wrStrobe)
);

// File: tb/sim_pbus_seq.sv
`timescale 1ns/1ps
module sim_pbus_seq;

  localparam int DLEN = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [1:0]  addrMode = '0;
  logic [1:0]  portSize = '0;
  logic        busy;
  logic [7:0]  busDataOut;
  logic        busDataOe;
  logic [7:0]  busDataIn = '0;
  logic [9:0]  addrPins;
  logic        strobeLow, strobeHigh, strobeUpper, rdStrobe, wrStrobe;
  logic [7:0]  rdHold;

  always #2.5 clk = ~clk;

  pbus_seq #(.DATA_LEN(DLEN)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .addrMode(addrMode), .portSize(portSize),
    .busy(busy), .busDataOut(busDataOut), .busDataOe(busDataOe), .busDataIn(busDataIn),
    .addrPins(addrPins), .strobeLow(strobeLow), .strobeHigh(strobeHigh),
    .strobeUpper(strobeUpper), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .rdHold(rdHold)
  );

  typedef struct {
    logic [4:0] stb;   // {low, high, upper, rd, wr}
    logic       oe;
    logic [7:0] dout;
    logic [9:0] pins;
    logic [7:0] drv;
  } cycItem_t;

  cycItem_t scoreQ[$];
  int checks = 0;
  int errors = 0;
  logic [7:0] expHold = 8'h00;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expSlice(input bit nib, input int p, input logic [22:0] a);
    if (nib) return {4'h0, a[4*p +: 4]};
    if (p == 0) return a[7:0];
    if (p == 1) return a[15:8];
    return {1'b0, a[22:16]};
  endfunction

  function automatic logic [9:0] expPins(input logic [1:0] m, input bit nib, input logic [22:0] a);
    if (m == 2'b00) return a[9:0];
    if (nib) begin
      if (m == 2'b01) return {a[9:4], 4'h0};
      if (m == 2'b10) return {a[9:8], 8'h00};
      return {a[13:12], 8'h00};
    end
    if (m == 2'b01) return {a[9:8], 8'h00};
    return 10'd0;
  endfunction

  // driver: queue the expected bus cycles, then issue the request
  task automatic runTxn(input bit wr, input logic [22:0] a, input logic [7:0] d,
                        input logic [1:0] m, input logic [1:0] sz, input bit disturb);
    bit nib = (sz == 2'b01);
    int nPh = int'(m);
    int nBeats = nib ? 2 : 1;
    logic [9:0] pv = expPins(m, nib, a);
    for (int p = 0; p < nPh; p++) begin
      for (int h = 0; h < 2; h++) begin
        cycItem_t it;
        it.stb  = (h == 0) ? (5'b10000 >> p) : 5'b00000;
        it.oe   = 1'b1;
        it.dout = expSlice(nib, p, a);
        it.pins = pv;
        it.drv  = 8'h00;
        scoreQ.push_back(it);
      end
    end
    for (int b = 0; b < nBeats; b++) begin
      for (int c = 0; c < DLEN; c++) begin
        cycItem_t it;
        logic [7:0] good;
        good = nib ? ((b == 0) ? {4'hA, d[3:0]} : {4'h5, d[7:4]}) : d;
        it.stb  = wr ? 5'b00001 : 5'b00010;
        it.oe   = wr;
        it.dout = nib ? {4'h0, (b == 0) ? d[3:0] : d[7:4]} : d;
        it.pins = pv;
        it.drv  = (c == DLEN - 1) ? good : ~good;
        scoreQ.push_back(it);
      end
    end
    if (!wr) expHold = d;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    addrMode = m; portSize = sz;
    @(negedge clk);
    if (disturb) begin  // R10: inputs move while busy
      reqAddr = ~a; reqWdata = ~d; reqWrite = ~wr;
      addrMode = ~m; portSize = (sz == 2'b01) ? 2'b00 : 2'b01;
    end else begin
      reqValid = 1'b0;
    end
    while (busy) @(negedge clk);
    reqValid = 1'b0;
    busDataIn = 8'h00;
    check("R9 leftover cycles", scoreQ.size(), 0);
    check("R8 holding register", rdHold, expHold);
    check("R9 idle after transfer", busy, 1'b0);
  endtask

  // monitor: compare each busy cycle with the queued expectation
  always @(negedge clk) begin
    if (rstN && busy && !done) begin
      if (scoreQ.size() == 0) begin
        check("R9 busy too long", busy, 1'b0);
      end else begin
        cycItem_t it;
        it = scoreQ.pop_front();
        busDataIn = it.drv;
        check("R1 strobes", {strobeLow, strobeHigh, strobeUpper, rdStrobe, wrStrobe}, it.stb);
        check("R7 drive enable", busDataOe, it.oe);
        check("R5 address pins", addrPins, it.pins);
        if (it.oe) check("R3 data lines", busDataOut, it.dout);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 1'b0);
    check("R11 strobes", {strobeLow, strobeHigh, strobeUpper, rdStrobe, wrStrobe}, 5'd0);
    check("R11 enable", busDataOe, 1'b0);
    check("R11 pins", addrPins, 10'd0);
    check("R11 hold", rdHold, 8'd0);

    // R3 writes, 8-bit port, all modes
    runTxn(1'b1, 23'h5A3C81, 8'hC3, 2'b00, 2'b00, 1'b0);
    runTxn(1'b1, 23'h5A3C81, 8'h3C, 2'b01, 2'b00, 1'b0);
    runTxn(1'b1, 23'h5A3C81, 8'h77, 2'b10, 2'b00, 1'b0);
    runTxn(1'b1, 23'h7FFFFF, 8'h18, 2'b11, 2'b00, 1'b0);
    // R4 writes, 4-bit port, all modes; R6 two beats
    runTxn(1'b1, 23'h7FFFFF, 8'hE1, 2'b11, 2'b01, 1'b0);
    runTxn(1'b1, 23'h5A3C81, 8'h9D, 2'b10, 2'b01, 1'b0);
    runTxn(1'b1, 23'h7FFFFF, 8'h42, 2'b01, 2'b01, 1'b0);
    runTxn(1'b1, 23'h5A3C81, 8'hB5, 2'b00, 2'b01, 1'b0);
    // R4 size value 10 behaves as 8-bit
    runTxn(1'b1, 23'h12ABCD, 8'h66, 2'b10, 2'b10, 1'b0);
    // R8 reads, last-clock sampling
    runTxn(1'b0, 23'h7FFFFF, 8'h96, 2'b11, 2'b00, 1'b0);
    runTxn(1'b0, 23'h5A3C81, 8'h4E, 2'b11, 2'b01, 1'b0);
    runTxn(1'b0, 23'h0003FF, 8'h21, 2'b00, 2'b00, 1'b0);
    // R8 write leaves holding register
    runTxn(1'b1, 23'h001234, 8'hFF, 2'b01, 2'b00, 1'b0);
    // R10 inputs disturbed while busy
    runTxn(1'b0, 23'h2468AC, 8'hB7, 2'b10, 2'b01, 1'b1);
    runTxn(1'b1, 23'h13579B, 8'h5E, 2'b01, 2'b00, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 stays idle", busy, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule